// File: doc/BRIEF.md
# Multi-channel transceiver setting broadcaster

This controller holds two small analog-control settings for each of N transceiver channels: a transmit output level and a receive equalizer level, each 3 bits wide. One strobe copies a shared pair of input values into every channel. A 2-bit direction select decides which side of the channels is written: the transmit side, the receive side, both, or neither. The controller writes the channels one at a time. Each channel write takes a fixed number of clock cycles, and `busy` stays high until the last channel is done.

Software cannot see the channel registers directly. A read request with a channel index copies that channel's current settings into two packed readback vectors, which hold one 3-bit field per channel. The field for channel c sits at bits [3c+2:3c]. A read also holds `busy` high for one channel slot. The readback vectors change only when a read completes.

Top module: `xcvr_bcast`

## Requirements
- R1: After a synchronous reset, `busy` is low, both readback vectors are zero, and every channel register holds zero.
- R2: When `busy` is low, a one-cycle `wr_all` pulse with `dir_sel` not equal to 2'b00 starts a write. `busy` rises at the next clock edge and stays high for exactly N×4 cycles.
- R3: A write puts the same captured values into every channel, for each side that `dir_sel` selects.
- R4: `dir_sel` = 2'b10 writes only the transmit level. Receive levels keep their old values.
- R5: `dir_sel` = 2'b01 writes only the receive level. `dir_sel` = 2'b11 writes both levels.
- R6: `dir_sel` = 2'b00 changes no channel register. It still raises `busy` for exactly one cycle.
- R7: The controller ignores `wr_all` and `rd_req` while `busy` is high. They change neither the write in progress nor the readback vectors.
- R8: The setting inputs and `dir_sel` are captured on the cycle the strobe is accepted. Later changes to them do not affect the write in progress.
- R9: When `busy` is low, `rd_req` holds `busy` high for 4 cycles. After that, only field `rd_chan` of each readback vector (bits [3c+2:3c] for channel c) takes that channel's current register values. The other fields keep their values, and the readback vectors do not change at any other time.
- R10: During a write, the channels are committed in ascending index order, one every 4 cycles, starting with channel 0. `busy` falls on the cycle after the last channel is committed.
- R11: If `wr_all` and `rd_req` are both high in the same idle cycle, the write is taken and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_all | input | 1 | One-cycle strobe that starts a broadcast write |
| dir_sel | input | 2 | Side select: bit 1 selects transmit, bit 0 selects receive |
| tx_lvl_in | input | 3 | Shared transmit output level to broadcast |
| rx_eq_in | input | 3 | Shared receive equalizer level to broadcast |
| rd_req | input | 1 | One-cycle read request |
| rd_chan | input | $clog2(N) (min 1) | Channel index to read |
| busy | output | 1 | High while a write or read is in progress |
| tx_lvl_rb | output | N×3 | Packed transmit level readback, channel c at [3c+2:3c] |
| rx_eq_rb | output | N×3 | Packed receive level readback, channel c at [3c+2:3c] |

## Verification
Some internal faults show only through `busy`. A wrong slot counter or a wrong channel counter changes the length of the busy window at once, by a multiple of the slot length for a write, or by any amount for a read or a no-op.

Other faults reach the ports later. A missed or misdirected commit, a wrong side gate, or a value that is not held after capture stays hidden until a read of the affected channel. So the bench reads back every channel after every write.

A wrong readback field offset corrupts a neighbouring field on the next read. The bench compares the whole packed vectors, so this shows at that read.

// File: rtl/xcvr_bcast_pkg.sv
package xcvr_bcast_pkg;
  localparam int unsigned SLOT_CYC = 4;
  localparam int unsigned SLOT_W   = $clog2(SLOT_CYC);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_NOP  = 2'd3
  } seq_state_t;

  localparam logic [1:0] DIR_NONE = 2'b00;
endpackage

// File: rtl/xcvr_bcast_seq.sv
module xcvr_bcast_seq
  import xcvr_bcast_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 3,
  parameter int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_all,
  input  logic [1:0]    dir_sel,
  input  logic [W-1:0]  tx_in,
  input  logic [W-1:0]  rx_in,
  input  logic          rd_req,
  input  logic [CW-1:0] rd_chan,
  output logic          busy,
  output logic [CW-1:0] cur_chan,
  output logic          commit,
  output logic          rd_done,
  output logic          tx_en,
  output logic          rx_en,
  output logic [W-1:0]  tx_cap,
  output logic [W-1:0]  rx_cap
);
  localparam logic [CW-1:0]     LAST_CH   = CW'(N - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_CYC - 1);

  seq_state_t        state;
  logic [SLOT_W-1:0] cnt;
  logic              slot_end;

  assign slot_end = (cnt == LAST_SLOT);
  assign commit   = (state == ST_WR) && slot_end;
  assign rd_done  = (state == ST_RD) && slot_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      cnt      <= '0;
      cur_chan <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      tx_cap   <= '0;
      rx_cap   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (wr_all) begin
            tx_cap   <= tx_in;
            rx_cap   <= rx_in;
            tx_en    <= dir_sel[1];
            rx_en    <= dir_sel[0];
            cur_chan <= '0;
            busy     <= 1'b1;
            state    <= (dir_sel == DIR_NONE) ? ST_NOP : ST_WR;
          end else if (rd_req) begin
            cur_chan <= rd_chan;
            busy     <= 1'b1;
            state    <= ST_RD;
          end
        end
        ST_NOP: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_WR: begin
          if (slot_end) begin
            cnt <= '0;
            if (cur_chan == LAST_CH) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              cur_chan <= cur_chan + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD: begin
          if (slot_end) begin
            cnt   <= '0;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_chan_bank.sv
module xcvr_chan_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 3,
  parameter int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic [CW-1:0]  chan,
  input  logic           tx_en,
  input  logic           rx_en,
  input  logic [W-1:0]   tx_val,
  input  logic [W-1:0]   rx_val,
  output logic [N*W-1:0] tx_all,
  output logic [N*W-1:0] rx_all
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [W-1:0] tx_q, rx_q;
    logic         hit;
    assign hit = commit && (chan == CW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        tx_q <= '0;
        rx_q <= '0;
      end else if (hit) begin
        if (tx_en) tx_q <= tx_val;
        if (rx_en) rx_q <= rx_val;
      end
    end

    assign tx_all[c*W +: W] = tx_q;
    assign rx_all[c*W +: W] = rx_q;
  end
endmodule

// File: rtl/xcvr_rb_pack.sv
module xcvr_rb_pack #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 3,
  parameter int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_done,
  input  logic [CW-1:0]  chan,
  input  logic [N*W-1:0] tx_all,
  input  logic [N*W-1:0] rx_all,
  output logic [N*W-1:0] tx_rb,
  output logic [N*W-1:0] rx_rb
);
  for (genvar c = 0; c < N; c++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_rb[c*W +: W] <= '0;
        rx_rb[c*W +: W] <= '0;
      end else if (rd_done && (chan == CW'(c))) begin
        tx_rb[c*W +: W] <= tx_all[c*W +: W];
        rx_rb[c*W +: W] <= rx_all[c*W +: W];
      end
    end
  end
endmodule

// File: rtl/xcvr_bcast.sv
module xcvr_bcast #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 3,
  parameter int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_all,
  input  logic [1:0]     dir_sel,
  input  logic [W-1:0]   tx_lvl_in,
  input  logic [W-1:0]   rx_eq_in,
  input  logic           rd_req,
  input  logic [CW-1:0]  rd_chan,
  output logic           busy,
  output logic [N*W-1:0] tx_lvl_rb,
  output logic [N*W-1:0] rx_eq_rb
);
  logic [CW-1:0]  cur_chan;
  logic           commit, rd_done, tx_en, rx_en;
  logic [W-1:0]   tx_cap, rx_cap;
  logic [N*W-1:0] tx_all, rx_all;

  xcvr_bcast_seq #(.N(N), .W(W), .CW(CW)) i_seq (
    .clk(clk), .rst(rst), .wr_all(wr_all), .dir_sel(dir_sel),
    .tx_in(tx_lvl_in), .rx_in(rx_eq_in), .rd_req(rd_req), .rd_chan(rd_chan),
    .busy(busy), .cur_chan(cur_chan), .commit(commit), .rd_done(rd_done),
    .tx_en(tx_en), .rx_en(rx_en), .tx_cap(tx_cap), .rx_cap(rx_cap)
  );

  xcvr_chan_bank #(.N(N), .W(W), .CW(CW)) i_bank (
    .clk(clk), .rst(rst), .commit(commit), .chan(cur_chan),
    .tx_en(tx_en), .rx_en(rx_en), .tx_val(tx_cap), .rx_val(rx_cap),
    .tx_all(tx_all), .rx_all(rx_all)
  );

  xcvr_rb_pack #(.N(N), .W(W), .CW(CW)) i_pack (
    .clk(clk), .rst(rst), .rd_done(rd_done), .chan(cur_chan),
    .tx_all(tx_all), .rx_all(rx_all), .tx_rb(tx_lvl_rb), .rx_rb(rx_eq_rb)
  );
endmodule

// File: rtl/xcvr_bcast_chk.sv
module xcvr_bcast_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 3,
  parameter int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_all,
  input logic [1:0]     dir_sel,
  input logic           busy,
  input logic           commit,
  input logic           rd_done,
  input logic [CW-1:0]  cur_chan,
  input logic [N*W-1:0] tx_lvl_rb,
  input logic [N*W-1:0] rx_eq_rb
);
  // R1: reset leaves the controller idle
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !busy);

  // R2: accepted strobe raises busy
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_all) |=> busy);

  // R6: empty direction gives a single busy cycle
  a_r6_nop_pulse: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_all && dir_sel == 2'b00) |=> busy ##1 !busy);

  // R10: ascending order, one commit per slot
  a_r10_order: assert property (@(posedge clk) disable iff (rst)
    (commit && cur_chan != CW'(N - 1)) |-> ##4
      (commit && cur_chan == CW'($past(cur_chan, 4) + 1'b1)));

  // R10: busy falls right after the last commit
  a_r10_last_done: assert property (@(posedge clk) disable iff (rst)
    (commit && cur_chan == CW'(N - 1)) |=> !busy);

  // R9: readback moves only on a finished read
  a_r9_rb_stable: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> ($stable(tx_lvl_rb) && $stable(rx_eq_rb)));
endmodule

bind xcvr_bcast xcvr_bcast_chk #(.N(N), .W(W), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .wr_all(wr_all), .dir_sel(dir_sel), .busy(busy),
  .commit(commit), .rd_done(rd_done), .cur_chan(cur_chan),
  .tx_lvl_rb(tx_lvl_rb), .rx_eq_rb(rx_eq_rb)
);

// File: tb/test_xcvr_bcast.sv
`timescale 1ns/1ps
module test_xcvr_bcast;
  localparam int N  = 4;
  localparam int W  = 3;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_all = 1'b0;
  logic [1:0]    dir_sel = 2'b00;
  logic [W-1:0]  tx_lvl_in = '0;
  logic [W-1:0]  rx_eq_in = '0;
  logic          rd_req = 1'b0;
  logic [CW-1:0] rd_chan = '0;
  logic          busy;
  logic [N*W-1:0] tx_lvl_rb, rx_eq_rb;

  int checks = 0;
  int errors = 0;
  logic [W-1:0]   m_tx [N];
  logic [W-1:0]   m_rx [N];
  logic [N*W-1:0] e_txrb, e_rxrb;

  always #2 clk = ~clk;

  xcvr_bcast #(.N(N), .W(W), .CW(CW)) i_xcvr_bcast (
    .clk(clk), .rst(rst), .wr_all(wr_all), .dir_sel(dir_sel),
    .tx_lvl_in(tx_lvl_in), .rx_eq_in(rx_eq_in), .rd_req(rd_req),
    .rd_chan(rd_chan), .busy(busy), .tx_lvl_rb(tx_lvl_rb), .rx_eq_rb(rx_eq_rb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_rb(input string req);
    check(tx_lvl_rb == e_txrb, req, int'(tx_lvl_rb), int'(e_txrb));
    check(rx_eq_rb == e_rxrb, req, int'(rx_eq_rb), int'(e_rxrb));
  endtask

  // read one channel; the bench is at a negedge with busy low
  task automatic do_read(input int ch, input string req);
    int n = 0;
    rd_req = 1'b1; rd_chan = CW'(ch);
    @(negedge clk);
    rd_req = 1'b0; rd_chan = '0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check(n == 4, req, n, 4);  // R9 busy window
    e_txrb[ch*W +: W] = m_tx[ch];
    e_rxrb[ch*W +: W] = m_rx[ch];
    check_rb(req);
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < N; c++) do_read(c, req);
  endtask

  // broadcast write; inj adds stray strobes while busy (R7, R8)
  task automatic do_write(input logic [1:0] d, input logic [W-1:0] tv,
                          input logic [W-1:0] rv, input bit inj, input bit with_rd,
                          input string req);
    int n = 0;
    int exp_n = (d == 2'b00) ? 1 : N * 4;
    wr_all = 1'b1; dir_sel = d; tx_lvl_in = tv; rx_eq_in = rv;
    rd_req = with_rd; rd_chan = 2'd1;
    @(negedge clk);
    wr_all = 1'b0; rd_req = 1'b0;
    dir_sel = ~d; tx_lvl_in = ~tv; rx_eq_in = ~rv;  // R8 late change
    while (busy && n < 100) begin
      n++;
      if (inj && n == 5) begin wr_all = 1'b1; dir_sel = 2'b11; rd_req = 1'b1; rd_chan = 2'd0; end
      if (inj && n == 6) begin wr_all = 1'b0; rd_req = 1'b0; end
      @(negedge clk);
    end
    check(n == exp_n, req, n, exp_n);
    for (int c = 0; c < N; c++) begin
      if (d[1]) m_tx[c] = tv;
      if (d[0]) m_rx[c] = rv;
    end
    check_rb({req, " rb untouched by write"});  // R7/R9
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < N; c++) begin m_tx[c] = '0; m_rx[c] = '0; end
    e_txrb = '0; e_rxrb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check_rb("R1 readback");
    read_all("R1 regs zero");

    // sweep every direction with several values (R2-R6, R10)
    for (int d = 0; d < 4; d++) begin
      for (int v = 1; v < 8; v += 3) begin
        do_write(2'(d), 3'(v), 3'(7 - v + d), 1'b0, 1'b0,
                 (d == 0) ? "R6" : (d == 2) ? "R4 R2 R10" : "R5 R2 R10");
        read_all((d == 0) ? "R6 no change" : (d == 2) ? "R4 R3" : "R5 R3");
      end
    end

    // strobes and reads while busy are ignored, inputs captured (R7, R8)
    do_write(2'b11, 3'd2, 3'd6, 1'b1, 1'b0, "R7 R8");
    read_all("R7 R8 captured values");

    // simultaneous write and read: write wins (R11)
    do_write(2'b10, 3'd4, 3'd1, 1'b0, 1'b1, "R11");
    read_all("R11 write taken");

    // single reads leave other fields alone (R9)
    do_write(2'b01, 3'd0, 3'd3, 1'b0, 1'b0, "R5 rx only");
    do_read(2, "R9 single field");
    do_read(0, "R9 single field");

    finish_run();
  end
endmodule